// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block sits between a set of free-running clock sources and the clock pins they drive. There are three groups: a processor group, a peripheral-bus group and a memory group, and each has its own source clock. Each group has one asynchronous active-low stop request. The block synchronizes that request to the group's own clock. It then closes or opens the group's gates only while the clock is low. A stopped output therefore rests at 0, and the first pulse after a restart is a full high phase. A glitch never appears at either edge.

Individual outputs can be held low by enable bits from a register file. One processor output can be exempted from the stop request by a control bit. The last peripheral output never responds to its group's request. A strap input selects the role of the three shared pins. In mobile mode (1) the requests are honoured and the shared clock outputs rest low. In desktop mode (0) the requests are ignored and the shared outputs run as extra memory-group clocks. Each group also enforces a minimum running time before it accepts a new stop. A restart is never delayed by that time.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every clock output is 0. Once reset has been released and a few source cycles have passed, every enabled output delivers one high phase per source cycle.
- R2: When mode is 1 and a stop request falls during the low phase before rising edge k of its group clock, the group still delivers the high phases of edges k, k+1 and k+2. From edge k+3 onward it is held at 0, provided that the minimum running time has already passed. The other groups are not affected.
- R3: When a stop request rises during the low phase before edge k, the stopped outputs stay low at edges k, k+1 and k+2. Each then delivers a full high phase from edge k+3. This holds even if the group stopped only one cycle earlier.
- R4: A gate opens or closes only while its source clock is low. A high phase that has started is never cut short, and a stopped output is never left high.
- R5: After a restart whose first pulse is at edge r+1, a stop request that is re-asserted at once ends the pulses at edge r+max(MIN_ON,4). The output delivers at least MIN_ON pulses. MIN_ON is 100 for the processor group, 10 for the peripheral group and 1 for the memory group by default.
- R6: `pci_free_clk_out` ignores the peripheral stop request. When `cpu_free_sel` is 1, the highest-index processor output ignores the processor stop request. When `cpu_free_sel` returns to 0 while the request is active, that output stops from the next high phase.
- R7: When mode is 0, all three stop requests are ignored and `share_clk_out` runs on the memory clock under `share_en`. When mode is 1, `share_clk_out` is held at 0. Switching mode to 1 while a request is already low stops the group after one more pulse.
- R8: An enable bit at 0 holds its output at 0. A change to an enable bit made during the high phase of edge j leaves that high phase whole and takes effect from edge j+1.
- R9: The memory group finishes its current high phase before it stops. It follows the same three-pulse latency as the other groups and applies no extra minimum running time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mobile | input | 1 | Strap: 1 honours stop requests, 0 makes the shared pins clock outputs |
| cpu_clk_in | input | 1 | Processor group source clock |
| cpu_stop_n | input | 1 | Asynchronous active-low processor stop request |
| cpu_en | input | NCPU | Per-output enables, processor group |
| cpu_free_sel | input | 1 | 1 exempts output NCPU-1 from the processor stop request |
| cpu_clk_out | output | NCPU | Gated processor clocks |
| pci_clk_in | input | 1 | Peripheral group source clock |
| pci_stop_n | input | 1 | Asynchronous active-low peripheral stop request |
| pci_en | input | NPCI | Per-output enables, peripheral group |
| pci_free_en | input | 1 | Enable of the free-running peripheral output |
| pci_clk_out | output | NPCI | Gated peripheral clocks |
| pci_free_clk_out | output | 1 | Peripheral clock that ignores the stop request |
| mem_clk_in | input | 1 | Memory group source clock |
| mem_stop_n | input | 1 | Asynchronous active-low memory stop request |
| mem_en | input | NMEM | Per-output enables, memory group |
| share_en | input | NSHARE | Enables of the shared-pin clock outputs |
| mem_clk_out | output | NMEM | Gated memory clocks |
| share_clk_out | output | NSHARE | Shared-pin clocks, active in desktop mode only |

## Verification
The assertions check four things on every cycle of each group's clock. No gate changes during a high phase. A group never halts before its minimum running time. Mode 0 always keeps the group running. A halted group closes every gate that is not exempt. Only the bench's scenarios can show the exact latency counts measured from the request pins: the three-pulse delay, the restart edge, and the max(MIN_ON,4) end point after a quick re-stop. The same applies to the exemption control and to the mode handover seen at the output pins.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;
  // Flops in each request synchronizer.
  localparam int SYNC_DEPTH = 2;

  typedef enum logic {ST_RUN = 1'b0, ST_HALT = 1'b1} run_state_t;

  // Counter width able to hold 0 .. limit-1.
  function automatic int cnt_width(input int limit);
    return (limit <= 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/stop_sync.sv
`timescale 1ns/1ps
module stop_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [DEPTH-1:0] chain;

  // Chain resets to "not requested" so a group starts running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[DEPTH-2:0], async_n};
  end

  assign sync_n = chain[DEPTH-1];
endmodule

// File: rtl/stop_ctrl.sv
`timescale 1ns/1ps
module stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int MIN_ON = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic honor,
  input  logic req_n_sync,
  output logic run
);
  localparam int CW = cnt_width(MIN_ON);
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_ON - 1);

  run_state_t     state;
  logic [CW-1:0]  on_cnt;
  logic           req;

  assign req = honor & ~req_n_sync;

  // The on-time counter only delays a stop; a restart is taken at once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      on_cnt <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (on_cnt != CNT_LAST) on_cnt <= on_cnt + 1'b1;
          if (req && (on_cnt == CNT_LAST)) state <= ST_HALT;
        end
        default: begin
          on_cnt <= '0;
          if (!req) state <= ST_RUN;
        end
      endcase
    end
  end

  assign run = (state == ST_RUN);
endmodule

// File: rtl/gate_cell.sv
`timescale 1ns/1ps
module gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  output logic gate
);
  // Updated on the falling edge, so the gate moves only while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= allow;
  end
endmodule

// File: rtl/clk_gate_group.sv
`timescale 1ns/1ps
module clk_gate_group
  import clk_stop_pkg::*;
#(
  parameter int N      = 2,
  parameter int MIN_ON = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         honor,
  input  logic         stop_n,
  input  logic [N-1:0] en,
  input  logic [N-1:0] exempt,
  output logic [N-1:0] clk_out
);
  logic         req_n_sync;
  logic         run;
  logic [N-1:0] allow;
  logic [N-1:0] gate;

  stop_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (stop_n),
    .sync_n  (req_n_sync)
  );

  stop_ctrl #(.MIN_ON(MIN_ON)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .honor      (honor),
    .req_n_sync (req_n_sync),
    .run        (run)
  );

  for (genvar i = 0; i < N; i++) begin : g_out
    assign allow[i] = en[i] & (run | exempt[i]);
    gate_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .allow (allow[i]),
      .gate  (gate[i])
    );
    assign clk_out[i] = clk & gate[i];
  end
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
  parameter int NCPU       = 3,
  parameter int NPCI       = 5,
  parameter int NMEM       = 10,
  parameter int NSHARE     = 3,
  parameter int CPU_MIN_ON = 100,
  parameter int PCI_MIN_ON = 10,
  parameter int MEM_MIN_ON = 1
) (
  input  logic              rst_n,
  input  logic              mode_mobile,
  input  logic              cpu_clk_in,
  input  logic              cpu_stop_n,
  input  logic [NCPU-1:0]   cpu_en,
  input  logic              cpu_free_sel,
  output logic [NCPU-1:0]   cpu_clk_out,
  input  logic              pci_clk_in,
  input  logic              pci_stop_n,
  input  logic [NPCI-1:0]   pci_en,
  input  logic              pci_free_en,
  output logic [NPCI-1:0]   pci_clk_out,
  output logic              pci_free_clk_out,
  input  logic              mem_clk_in,
  input  logic              mem_stop_n,
  input  logic [NMEM-1:0]   mem_en,
  input  logic [NSHARE-1:0] share_en,
  output logic [NMEM-1:0]   mem_clk_out,
  output logic [NSHARE-1:0] share_clk_out
);
  localparam int NPCI_ALL = NPCI + 1;
  localparam int NMEM_ALL = NMEM + NSHARE;

  logic [NCPU-1:0]     cpu_exempt;
  logic [NPCI_ALL-1:0] pci_en_all, pci_exempt, pci_gclk;
  logic [NMEM_ALL-1:0] mem_en_all, mem_exempt, mem_gclk;

  always_comb begin
    cpu_exempt           = '0;
    cpu_exempt[NCPU-1]   = cpu_free_sel;
  end

  assign pci_en_all = {pci_free_en, pci_en};
  assign pci_exempt = {1'b1, {NPCI{1'b0}}};
  assign mem_en_all = {share_en & {NSHARE{~mode_mobile}}, mem_en};
  assign mem_exempt = '0;

  clk_gate_group #(.N(NCPU), .MIN_ON(CPU_MIN_ON)) u_cpu (
    .clk     (cpu_clk_in),
    .rst_n   (rst_n),
    .honor   (mode_mobile),
    .stop_n  (cpu_stop_n),
    .en      (cpu_en),
    .exempt  (cpu_exempt),
    .clk_out (cpu_clk_out)
  );

  clk_gate_group #(.N(NPCI_ALL), .MIN_ON(PCI_MIN_ON)) u_pci (
    .clk     (pci_clk_in),
    .rst_n   (rst_n),
    .honor   (mode_mobile),
    .stop_n  (pci_stop_n),
    .en      (pci_en_all),
    .exempt  (pci_exempt),
    .clk_out (pci_gclk)
  );

  clk_gate_group #(.N(NMEM_ALL), .MIN_ON(MEM_MIN_ON)) u_mem (
    .clk     (mem_clk_in),
    .rst_n   (rst_n),
    .honor   (mode_mobile),
    .stop_n  (mem_stop_n),
    .en      (mem_en_all),
    .exempt  (mem_exempt),
    .clk_out (mem_gclk)
  );

  assign pci_clk_out      = pci_gclk[NPCI-1:0];
  assign pci_free_clk_out = pci_gclk[NPCI];
  assign mem_clk_out      = mem_gclk[NMEM-1:0];
  assign share_clk_out    = mem_gclk[NMEM_ALL-1:NMEM];
endmodule

// File: rtl/clk_gate_chk.sv
`timescale 1ns/1ps
module clk_gate_chk
  import clk_stop_pkg::*;
#(
  parameter int N      = 2,
  parameter int MIN_ON = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         honor,
  input logic         run,
  input logic [N-1:0] exempt,
  input logic [N-1:0] gate
);
  localparam int KW = cnt_width(MIN_ON + 1);

  logic [KW-1:0] run_cnt;
  logic [N-1:0]  hi_snap;

  // Independent count of sampled running cycles since the last restart.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run_cnt <= '0;
    else if (!run)                  run_cnt <= '0;
    else if (run_cnt != KW'(MIN_ON)) run_cnt <= run_cnt + 1'b1;
  end

  // Gate state as it entered the high phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_snap <= '0;
    else        hi_snap <= gate;
  end

  p_full_high_r4: assert property (@(negedge clk) disable iff (!rst_n)
    gate == hi_snap);

  p_min_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> (run_cnt == KW'(MIN_ON)));

  p_mode_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!honor && !$past(honor)) |-> run);

  for (genvar i = 0; i < N; i++) begin : g_bit
    p_halt_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !exempt[i] && !$past(exempt[i])) |-> !gate[i]);
  end
endmodule

bind clk_gate_group clk_gate_chk #(.N(N), .MIN_ON(MIN_ON)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .honor  (honor),
  .run    (run),
  .exempt (exempt),
  .gate   (gate)
);

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb;
  localparam int NCPU = 3, NPCI = 2, NMEM = 2, NSHARE = 3;
  localparam int CPU_M = 6, PCI_M = 5, MEM_M = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, mode_mobile;
  logic cpu_stop_n, pci_stop_n, mem_stop_n;
  logic [NCPU-1:0] cpu_en, cpu_clk_out;
  logic cpu_free_sel;
  logic [NPCI-1:0] pci_en, pci_clk_out;
  logic pci_free_en, pci_free_clk_out;
  logic [NMEM-1:0] mem_en, mem_clk_out;
  logic [NSHARE-1:0] share_en, share_clk_out;

  int n_chk = 0;
  int n_fail = 0;

  clk_stop_gate #(
    .NCPU(NCPU), .NPCI(NPCI), .NMEM(NMEM), .NSHARE(NSHARE),
    .CPU_MIN_ON(CPU_M), .PCI_MIN_ON(PCI_M), .MEM_MIN_ON(MEM_M)
  ) u_dut (
    .rst_n(rst_n), .mode_mobile(mode_mobile),
    .cpu_clk_in(clk), .cpu_stop_n(cpu_stop_n), .cpu_en(cpu_en),
    .cpu_free_sel(cpu_free_sel), .cpu_clk_out(cpu_clk_out),
    .pci_clk_in(clk), .pci_stop_n(pci_stop_n), .pci_en(pci_en),
    .pci_free_en(pci_free_en), .pci_clk_out(pci_clk_out),
    .pci_free_clk_out(pci_free_clk_out),
    .mem_clk_in(clk), .mem_stop_n(mem_stop_n), .mem_en(mem_en),
    .share_en(share_en), .mem_clk_out(mem_clk_out),
    .share_clk_out(share_clk_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Rising edge, then 5 ns into the high phase.
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  // From the high-phase sample point into the low phase.
  task automatic to_low();
    #10;
  endtask

  function automatic int last_hi(input int m);
    return ((m > 4) ? m : 4) - 1;
  endfunction

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; mode_mobile = 1;
    cpu_stop_n = 1; pci_stop_n = 1; mem_stop_n = 1;
    cpu_en = '1; cpu_free_sel = 0; pci_en = '1; pci_free_en = 1;
    mem_en = '1; share_en = '1;

    repeat (3) tick();
    check("R1 reset cpu", 8'(cpu_clk_out), 0);
    check("R1 reset pci", 8'({pci_free_clk_out, pci_clk_out}), 0);
    check("R1 reset mem", 8'({share_clk_out, mem_clk_out}), 0);
    to_low(); rst_n = 1;
    repeat (12) tick();
    check("R1 run cpu", 8'(cpu_clk_out), 8'h7);
    check("R1 run pci", 8'({pci_free_clk_out, pci_clk_out}), 8'h7);
    check("R1 run mem", 8'(mem_clk_out), 8'h3);
    check("R7 share low in mobile", 8'(share_clk_out), 0);

    // R2 processor stop latency
    to_low(); cpu_stop_n = 0;
    for (int j = 0; j < 4; j++) begin
      tick();
      check("R2 cpu off latency", 8'(cpu_clk_out), (j < 3) ? 8'h7 : 8'h0);
    end
    check("R2 pci unaffected", 8'(pci_clk_out), 8'h3);
    repeat (3) tick();
    check("R2 cpu held", 8'(cpu_clk_out), 0);
    to_low();
    check("R4 stopped rests low", 8'(cpu_clk_out), 0);

    // R3 restart latency
    cpu_stop_n = 1;
    for (int j = 0; j < 4; j++) begin
      tick();
      check("R3 cpu on latency", 8'(cpu_clk_out), (j < 3) ? 8'h0 : 8'h7);
    end

    // R5 quick re-stop honours the minimum running time
    to_low(); cpu_stop_n = 0;
    for (int j = 0; j <= last_hi(CPU_M); j++) begin
      tick();
      check("R5 cpu min on", 8'(cpu_clk_out), (j < last_hi(CPU_M)) ? 8'h7 : 8'h0);
    end

    // R3 restart right after a stop
    to_low(); cpu_stop_n = 1;
    for (int j = 0; j < 4; j++) begin
      tick();
      check("R3 cpu quick restart", 8'(cpu_clk_out), (j < 3) ? 8'h0 : 8'h7);
    end

    // R6 exempt processor output
    repeat (8) tick();
    cpu_free_sel = 1; tick();
    to_low(); cpu_stop_n = 0;
    for (int j = 0; j < 4; j++) begin
      tick();
      check("R6 cpu exempt", 8'(cpu_clk_out), (j < 3) ? 8'h7 : 8'h4);
    end
    cpu_free_sel = 0; tick();
    check("R6 exemption removed", 8'(cpu_clk_out), 0);
    cpu_free_sel = 1; tick();
    check("R6 exemption restored", 8'(cpu_clk_out), 8'h4);
    to_low(); cpu_stop_n = 1;
    repeat (4) tick();
    check("R3 cpu resumed", 8'(cpu_clk_out), 8'h7);
    cpu_free_sel = 0;

    // Peripheral group
    to_low(); pci_stop_n = 0;
    for (int j = 0; j < 4; j++) begin
      tick();
      check("R2 pci off latency", 8'(pci_clk_out), (j < 3) ? 8'h3 : 8'h0);
    end
    check("R6 pci free runs", 8'(pci_free_clk_out), 8'h1);
    check("R2 cpu unaffected", 8'(cpu_clk_out), 8'h7);
    to_low(); pci_stop_n = 1;
    for (int j = 0; j < 4; j++) begin
      tick();
      check("R3 pci on latency", 8'(pci_clk_out), (j < 3) ? 8'h0 : 8'h3);
    end
    to_low(); pci_stop_n = 0;
    for (int j = 0; j <= last_hi(PCI_M); j++) begin
      tick();
      check("R5 pci min on", 8'(pci_clk_out), (j < last_hi(PCI_M)) ? 8'h3 : 8'h0);
    end
    to_low(); pci_stop_n = 1;
    repeat (4) tick();
    check("R3 pci resumed", 8'(pci_clk_out), 8'h3);

    // R9 memory group
    repeat (2) tick();
    to_low(); mem_stop_n = 0;
    for (int j = 0; j <= last_hi(MEM_M); j++) begin
      tick();
      check("R9 mem off latency", 8'(mem_clk_out), (j < last_hi(MEM_M)) ? 8'h3 : 8'h0);
    end
    check("R7 share stays low", 8'(share_clk_out), 0);
    to_low(); mem_stop_n = 1;
    for (int j = 0; j < 4; j++) begin
      tick();
      check("R9 mem on latency", 8'(mem_clk_out), (j < 3) ? 8'h0 : 8'h3);
    end

    // R8 enable bits
    repeat (4) tick();
    cpu_en = 3'b101; #3;
    check("R8 high phase kept", 8'(cpu_clk_out), 8'h7);
    tick();
    check("R8 disabled bit low", 8'(cpu_clk_out), 8'h5);
    cpu_en = 3'b111; #3;
    check("R4 no late start", 8'(cpu_clk_out), 8'h5);
    tick();
    check("R8 re-enabled", 8'(cpu_clk_out), 8'h7);
    mem_en = 2'b01; tick();
    check("R8 mem bit off", 8'(mem_clk_out), 8'h1);
    mem_en = 2'b11; tick();
    check("R8 mem bit on", 8'(mem_clk_out), 8'h3);

    // R7 desktop mode
    mode_mobile = 0; tick();
    check("R7 share runs", 8'(share_clk_out), 8'h7);
    to_low(); cpu_stop_n = 0; pci_stop_n = 0; mem_stop_n = 0;
    repeat (6) tick();
    check("R7 cpu ignores stop", 8'(cpu_clk_out), 8'h7);
    check("R7 pci ignores stop", 8'(pci_clk_out), 8'h3);
    check("R7 mem ignores stop", 8'(mem_clk_out), 8'h3);
    check("R7 share still runs", 8'(share_clk_out), 8'h7);
    share_en = 3'b010; tick();
    check("R7 share enable", 8'(share_clk_out), 8'h2);
    mode_mobile = 1; tick();
    check("R7 last cpu pulse", 8'(cpu_clk_out), 8'h7);
    check("R7 last pci pulse", 8'(pci_clk_out), 8'h3);
    check("R7 share off in mobile", 8'(share_clk_out), 0);
    tick();
    check("R7 cpu stopped", 8'(cpu_clk_out), 0);
    check("R7 pci stopped", 8'(pci_clk_out), 0);
    check("R7 mem stopped", 8'(mem_clk_out), 0);
    check("R6 pci free after mode", 8'(pci_free_clk_out), 8'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule